// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This controller carries out the hardware half of interrupt handling for a small 8-bit processor. Whenever the core reaches the end of an instruction it raises a one-cycle step strobe and offers its full register state (program counter, condition codes, two accumulators, two index registers and the stack pointer). The sequencer looks at two active-low request lines at that moment only. If a request is accepted, it writes the register state into a byte-wide stack in memory, sets the interrupt mask bit in the condition codes, reads the handler address from the vector slot of the winning source, and hands the new state back to the core with a one-cycle done pulse.

When the core executes a return-from-interrupt it raises a return strobe instead. The sequencer then reads the nine stacked bytes back in the reverse order and delivers the restored registers, including the old mask bit, with the same done pulse. Just after reset the sequencer fetches the reset vector and delivers it the same way. A step with nothing to accept gets an immediate done, with the registers passed through unchanged.

The memory port reads combinationally: `mem_rdata_i` must show the byte at `mem_addr_o` within the same cycle that `mem_re_o` is high.

Top module: `intr_seq`

## Requirements
- R1: While reset is held, `done_o` and `mem_we_o` stay low. After release the block reads 0xFFFE and then 0xFFFF, loads the program counter high byte first (first byte read is bits 15:8), pulses `done_o` with `entered_o` low, and then drops `busy_o`.
- R2: Requests are sampled only on the clock edge where `step_i` is high while `busy_o` is low. A request removed after that edge still completes its entry. A `step_i` raised while busy is ignored and produces no second done.
- R3: The maskable request (`irq_n_i` low) is ignored when `cc_i` bit 4 is 1. The non-maskable request (`nmi_n_i` low) is never ignored. With nothing accepted, `done_o` pulses in the next cycle with `entered_o` low and every register output equal to its input.
- R4: When both requests are active, the non-maskable source is taken and its vector is used.
- R5: On entry nine bytes are written at SP, SP-1, SP-2 and so on, in this order: PC[7:0], PC[15:8], CC, A, B, X[7:0], X[15:8], Y[7:0], Y[15:8]. After entry `sp_o` equals `sp_i` minus 9, and A, B, X and Y come back unchanged.
- R6: After entry `cc_o` equals `cc_i` with bit 4 forced to 1.
- R7: The new PC is {byte at 0xFFF2, byte at 0xFFF3} for the maskable source and {byte at 0xFFF4, byte at 0xFFF5} for the non-maskable source.
- R8: `done_o` is high for exactly one cycle. It is observed 12 cycles after the step strobe for an entry and 10 cycles after the return strobe for a return.
- R9: A return reads SP+1 up to SP+9 as Y[15:8], Y[7:0], X[15:8], X[7:0], B, A, CC, PC[15:8], PC[7:0]. The CC byte is restored exactly, including bit 4. `sp_o` equals `sp_i` plus 9, and `entered_o` is low.
- R10: If `ret_i` and `step_i` are raised in the same cycle, the return is performed and the step is dropped. The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Instruction boundary strobe |
| ret_i | input | 1 | Return-from-interrupt strobe |
| irq_n_i | input | 1 | Maskable request, active low, may be wire-ORed |
| nmi_n_i | input | 1 | Non-maskable request, active low |
| pc_i | input | 16 | Current program counter |
| cc_i | input | 8 | Current condition codes (bit 4 = mask) |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| x_i | input | 16 | Index register X |
| y_i | input | 16 | Index register Y |
| sp_i | input | 16 | Stack pointer |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, same cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| entered_o | output | 1 | Completion was an interrupt entry |
| pc_o | output | 16 | Program counter to load |
| cc_o | output | 8 | Condition codes to load |
| a_o | output | 8 | Accumulator A to load |
| b_o | output | 8 | Accumulator B to load |
| x_o | output | 16 | Index X to load |
| y_o | output | 16 | Index Y to load |
| sp_o | output | 16 | Stack pointer to load |

## Verification
Random entries cover every mix of the two request lines and the mask bit. This separates taken from ignored requests (R3) and the vector choice when both lines are low (R4, R7). Each entry is checked against the nine stacked bytes and the exact latency. Random returns use stack bytes unrelated to any earlier entry, so a byte read in the wrong order or from the wrong address shows up in the restored registers, and a restore with mask 0 shows that bit 4 is really popped. Directed cases cover a step strobe raised in the middle of an entry, requests removed right after sampling, and simultaneous return and step strobes.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
    localparam int DW          = 8;
    localparam int AW          = 16;
    localparam int WW          = 2 * DW;
    localparam int FRAME_BYTES = 9;
    localparam int CNT_W       = $clog2(FRAME_BYTES);
    localparam int I_BIT       = 4;

    localparam logic [AW-1:0]    VEC_IRQ  = 16'hFFF2;
    localparam logic [AW-1:0]    VEC_NMI  = 16'hFFF4;
    localparam logic [AW-1:0]    VEC_RST  = 16'hFFFE;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

    typedef enum logic [2:0] {
        ST_RV_HI,
        ST_RV_LO,
        ST_IDLE,
        ST_PUSH,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_POP
    } seq_st_e;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    sp;
        logic [WW-1:0]    pc;
        logic [DW-1:0]    cc;
        logic [DW-1:0]    a;
        logic [DW-1:0]    b;
        logic [WW-1:0]    x;
        logic [WW-1:0]    y;
        logic             use_nmi;
        logic             took;
        logic             done;
    } seq_regs_t;
endpackage

// File: rtl/intr_seq_arb.sv
module intr_seq_arb (
    input  logic irq_n_i,
    input  logic nmi_n_i,
    input  logic mask_i,
    output logic take_o,
    output logic nmi_o
);
    // Non-maskable source has priority and ignores the mask bit.
    always_comb begin
        nmi_o  = ~nmi_n_i;
        take_o = ~nmi_n_i | (~irq_n_i & ~mask_i);
    end
endmodule

// File: rtl/intr_seq_pushmux.sv
module intr_seq_pushmux
    import intr_seq_pkg::*;
(
    input  logic [CNT_W-1:0] idx_i,
    input  logic [WW-1:0]    pc_i,
    input  logic [DW-1:0]    cc_i,
    input  logic [DW-1:0]    a_i,
    input  logic [DW-1:0]    b_i,
    input  logic [WW-1:0]    x_i,
    input  logic [WW-1:0]    y_i,
    output logic [DW-1:0]    byte_o
);
    // Push order: PC, CC, A, B, X, Y; words low byte first.
    always_comb begin
        case (idx_i)
            CNT_W'(0): byte_o = pc_i[DW-1:0];
            CNT_W'(1): byte_o = pc_i[WW-1:DW];
            CNT_W'(2): byte_o = cc_i;
            CNT_W'(3): byte_o = a_i;
            CNT_W'(4): byte_o = b_i;
            CNT_W'(5): byte_o = x_i[DW-1:0];
            CNT_W'(6): byte_o = x_i[WW-1:DW];
            CNT_W'(7): byte_o = y_i[DW-1:0];
            default:   byte_o = y_i[WW-1:DW];
        endcase
    end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          ret_i,
    input  logic          irq_n_i,
    input  logic          nmi_n_i,
    input  logic [15:0]   pc_i,
    input  logic [7:0]    cc_i,
    input  logic [7:0]    a_i,
    input  logic [7:0]    b_i,
    input  logic [15:0]   x_i,
    input  logic [15:0]   y_i,
    input  logic [15:0]   sp_i,
    output logic [15:0]   mem_addr_o,
    output logic          mem_we_o,
    output logic          mem_re_o,
    output logic [7:0]    mem_wdata_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          entered_o,
    output logic [15:0]   pc_o,
    output logic [7:0]    cc_o,
    output logic [7:0]    a_o,
    output logic [7:0]    b_o,
    output logic [15:0]   x_o,
    output logic [15:0]   y_o,
    output logic [15:0]   sp_o
);
    seq_regs_t r_q, r_d;
    logic take, pick_nmi;
    logic [DW-1:0] push_byte;
    logic [AW-1:0] vec_base;

    intr_seq_arb u_arb (
        .irq_n_i (irq_n_i),
        .nmi_n_i (nmi_n_i),
        .mask_i  (cc_i[I_BIT]),
        .take_o  (take),
        .nmi_o   (pick_nmi)
    );

    intr_seq_pushmux u_pmux (
        .idx_i  (r_q.cnt),
        .pc_i   (r_q.pc),
        .cc_i   (r_q.cc),
        .a_i    (r_q.a),
        .b_i    (r_q.b),
        .x_i    (r_q.x),
        .y_i    (r_q.y),
        .byte_o (push_byte)
    );

    assign vec_base = r_q.use_nmi ? VEC_NMI : VEC_IRQ;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        mem_addr_o  = r_q.sp;
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_wdata_o = push_byte;
        case (r_q.st)
            ST_RV_HI: begin
                mem_re_o           = 1'b1;
                mem_addr_o         = VEC_RST;
                r_d.pc[WW-1:DW]    = mem_rdata_i;
                r_d.st             = ST_RV_LO;
            end
            ST_RV_LO: begin
                mem_re_o           = 1'b1;
                mem_addr_o         = VEC_RST + AW'(1);
                r_d.pc[DW-1:0]     = mem_rdata_i;
                r_d.took           = 1'b0;
                r_d.done           = 1'b1;
                r_d.st             = ST_IDLE;
            end
            ST_IDLE: begin
                if (ret_i || step_i) begin
                    r_d.pc      = pc_i;
                    r_d.cc      = cc_i;
                    r_d.a       = a_i;
                    r_d.b       = b_i;
                    r_d.x       = x_i;
                    r_d.y       = y_i;
                    r_d.sp      = sp_i;
                    r_d.cnt     = '0;
                    r_d.took    = 1'b0;
                    r_d.use_nmi = pick_nmi;
                    if (ret_i) begin
                        r_d.st = ST_POP;
                    end else if (take) begin
                        r_d.st = ST_PUSH;
                    end else begin
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_PUSH: begin
                mem_we_o = 1'b1;
                r_d.sp   = r_q.sp - AW'(1);
                r_d.cnt  = r_q.cnt + CNT_W'(1);
                if (r_q.cnt == LAST_IDX) begin
                    r_d.cc[I_BIT] = 1'b1;
                    r_d.st        = ST_VEC_HI;
                end
            end
            ST_VEC_HI: begin
                mem_re_o        = 1'b1;
                mem_addr_o      = vec_base;
                r_d.pc[WW-1:DW] = mem_rdata_i;
                r_d.st          = ST_VEC_LO;
            end
            ST_VEC_LO: begin
                mem_re_o        = 1'b1;
                mem_addr_o      = vec_base + AW'(1);
                r_d.pc[DW-1:0]  = mem_rdata_i;
                r_d.took        = 1'b1;
                r_d.done        = 1'b1;
                r_d.st          = ST_IDLE;
            end
            ST_POP: begin
                mem_re_o   = 1'b1;
                mem_addr_o = r_q.sp + AW'(1);
                r_d.sp     = r_q.sp + AW'(1);
                r_d.cnt    = r_q.cnt + CNT_W'(1);
                case (r_q.cnt)
                    CNT_W'(0): r_d.y[WW-1:DW]  = mem_rdata_i;
                    CNT_W'(1): r_d.y[DW-1:0]   = mem_rdata_i;
                    CNT_W'(2): r_d.x[WW-1:DW]  = mem_rdata_i;
                    CNT_W'(3): r_d.x[DW-1:0]   = mem_rdata_i;
                    CNT_W'(4): r_d.b           = mem_rdata_i;
                    CNT_W'(5): r_d.a           = mem_rdata_i;
                    CNT_W'(6): r_d.cc          = mem_rdata_i;
                    CNT_W'(7): r_d.pc[WW-1:DW] = mem_rdata_i;
                    default:   r_d.pc[DW-1:0]  = mem_rdata_i;
                endcase
                if (r_q.cnt == LAST_IDX) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_RV_HI;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = r_q.done;
    assign entered_o = r_q.took;
    assign pc_o      = r_q.pc;
    assign cc_o      = r_q.cc;
    assign a_o       = r_q.a;
    assign b_o       = r_q.b;
    assign x_o       = r_q.x;
    assign y_o       = r_q.y;
    assign sp_o      = r_q.sp;

    // R8: completion strobe lasts a single cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: a completed entry always hands back the mask bit set
    assert_entry_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && entered_o) |-> cc_o[I_BIT]);

    // R3: masked maskable request alone never starts a push
    assert_mask_honoured_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && step_i && !ret_i && nmi_n_i && cc_i[I_BIT]) |=> (r_q.st != ST_PUSH));

    // R4: active non-maskable line selects its own vector
    assert_nmi_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && step_i && !ret_i && !nmi_n_i) |=> (r_q.st == ST_PUSH && r_q.use_nmi));

    // R10: port never reads and writes together; writes only inside a sequence
    assert_port_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    // R5: stack writes happen only while the block is busy
    assert_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);
endmodule

// File: tb/test_intr_seq.sv
module test_intr_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_i = 1'b0, ret_i = 1'b0, irq_n_i = 1'b1, nmi_n_i = 1'b1;
    logic [15:0] pc_i = '0, x_i = '0, y_i = '0, sp_i = '0;
    logic [7:0]  cc_i = '0, a_i = '0, b_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_we_o, mem_re_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic        busy_o, done_o, entered_o;
    logic [15:0] pc_o, x_o, y_o, sp_o;
    logic [7:0]  cc_o, a_o, b_o;

    int n_chk = 0;
    int n_bad = 0;

    // Bench memory: stack page 0x01xx and the vector slots 0xFFF0..0xFFFF
    logic [7:0] stk [256];
    logic [7:0] vtab [16];
    logic       poke_en = 1'b0;
    logic [7:0] poke_a = '0, poke_d = '0;

    always #2.5 clk = ~clk;

    assign mem_rdata_i = (mem_addr_o[15:4] == 12'hFFF) ? vtab[mem_addr_o[3:0]] :
                         (mem_addr_o[15:8] == 8'h01)  ? stk[mem_addr_o[7:0]] : 8'h00;

    always @(posedge clk) begin
        if (poke_en) stk[poke_a] <= poke_d;
        else if (mem_we_o && mem_addr_o[15:8] == 8'h01) stk[mem_addr_o[7:0]] <= mem_wdata_o;
    end

    intr_seq i_intr_seq (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .ret_i(ret_i),
        .irq_n_i(irq_n_i), .nmi_n_i(nmi_n_i), .pc_i(pc_i), .cc_i(cc_i),
        .a_i(a_i), .b_i(b_i), .x_i(x_i), .y_i(y_i), .sp_i(sp_i),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .entered_o(entered_o),
        .pc_o(pc_o), .cc_o(cc_o), .a_o(a_o), .b_o(b_o),
        .x_o(x_o), .y_o(y_o), .sp_o(sp_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] vec_of(input logic [3:0] lo);
        return {vtab[lo], vtab[lo + 4'd1]};
    endfunction

    function automatic logic [7:0] frame_byte(input int i, input logic [15:0] pc, input logic [7:0] cc,
                                              input logic [7:0] a, input logic [7:0] b,
                                              input logic [15:0] x, input logic [15:0] y);
        case (i)
            0: return pc[7:0];
            1: return pc[15:8];
            2: return cc;
            3: return a;
            4: return b;
            5: return x[7:0];
            6: return x[15:8];
            7: return y[7:0];
            default: return y[15:8];
        endcase
    endfunction

    task automatic poke(input logic [7:0] adr, input logic [7:0] d);
        poke_en = 1'b1; poke_a = adr; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // Raises the strobes, drops requests after the sample edge, counts cycles to done.
    task automatic strobe_wait(input logic s, input logic r, input int again, output int lat);
        step_i = s; ret_i = r;
        @(negedge clk);
        step_i = 1'b0; ret_i = 1'b0;
        irq_n_i = 1'b1; nmi_n_i = 1'b1;
        lat = 1;
        while (!done_o && lat < 60) begin
            if (lat == again) step_i = 1'b1;
            @(negedge clk);
            step_i = 1'b0;
            lat++;
        end
    endtask

    task automatic entry(input logic [15:0] pc, input logic [7:0] cc, input logic [7:0] a,
                         input logic [7:0] b, input logic [15:0] x, input logic [15:0] y,
                         input logic [15:0] sp, input logic irqn, input logic nmin, input int again);
        int lat;
        bit take, use_nmi;
        logic [15:0] vexp;
        take    = !nmin || (!irqn && !cc[4]);
        use_nmi = !nmin;
        vexp    = use_nmi ? vec_of(4'h4) : vec_of(4'h2);
        pc_i = pc; cc_i = cc; a_i = a; b_i = b; x_i = x; y_i = y; sp_i = sp;
        irq_n_i = irqn; nmi_n_i = nmin;
        strobe_wait(1'b1, 1'b0, again, lat);
        if (take) begin
            chk(lat == 12, "R8 entry latency", lat, 12);
            chk(entered_o == 1'b1, "R3 request accepted", entered_o, 1);
            chk(pc_o == vexp, use_nmi ? "R4/R7 nmi vector" : "R7 irq vector", pc_o, vexp);
            chk(cc_o == (cc | 8'h10), "R6 mask set", cc_o, cc | 8'h10);
            chk(sp_o == sp - 16'd9, "R5 sp after push", sp_o, sp - 16'd9);
            chk({a_o, b_o, x_o, y_o} == {a, b, x, y}, "R5 regs kept", {a_o, b_o}, {a, b});
            for (int i = 0; i < 9; i++) begin
                logic [7:0] e, g;
                e = frame_byte(i, pc, cc, a, b, x, y);
                g = stk[8'(sp[7:0] - 8'(i))];
                chk(g == e, "R5 stacked byte", g, e);
            end
        end else begin
            chk(lat == 1, "R3 no-take latency", lat, 1);
            chk(entered_o == 1'b0, "R3 request ignored", entered_o, 0);
            chk(pc_o == pc && cc_o == cc && sp_o == sp, "R3 pass-through", pc_o, pc);
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
        chk(busy_o == 1'b0, "R8 idle after done", busy_o, 0);
    endtask

    task automatic do_ret(input logic [15:0] sp, input logic also_step, input logic [7:0] mask_bit);
        logic [7:0] pb [9];
        int lat;
        for (int k = 0; k < 9; k++) begin
            pb[k] = 8'($urandom);
            if (k == 6) pb[k][4] = mask_bit[0];
            poke(8'(sp[7:0] + 8'(k + 1)), pb[k]);
        end
        sp_i = sp; cc_i = 8'h10; irq_n_i = 1'b0; nmi_n_i = 1'b0;
        strobe_wait(also_step, 1'b1, 0, lat);
        chk(lat == 10, also_step ? "R10 return wins latency" : "R8 return latency", lat, 10);
        chk(entered_o == 1'b0, "R9 not an entry", entered_o, 0);
        chk(y_o == {pb[0], pb[1]}, "R9 Y", y_o, {pb[0], pb[1]});
        chk(x_o == {pb[2], pb[3]}, "R9 X", x_o, {pb[2], pb[3]});
        chk(b_o == pb[4] && a_o == pb[5], "R9 B/A", {b_o, a_o}, {pb[4], pb[5]});
        chk(cc_o == pb[6], "R9 CC incl mask", cc_o, pb[6]);
        chk(pc_o == {pb[7], pb[8]}, "R9 PC", pc_o, {pb[7], pb[8]});
        chk(sp_o == sp + 16'd9, "R9 sp after pop", sp_o, sp + 16'd9);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R8 return done pulse", {done_o, busy_o}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int lat, extra;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) vtab[i] = 8'h00;
        vtab[4'h2] = 8'h8A; vtab[4'h3] = 8'h31;
        vtab[4'h4] = 8'hC4; vtab[4'h5] = 8'h57;
        vtab[4'hE] = 8'hE0; vtab[4'hF] = 8'h12;
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;

        // R1: reset behaviour
        repeat (4) @(negedge clk);
        chk(done_o == 1'b0 && mem_we_o == 1'b0, "R1 quiet in reset", {done_o, mem_we_o}, 0);
        rst_n = 1'b1;
        lat = 0;
        while (!done_o && lat < 10) begin @(negedge clk); lat++; end
        chk(done_o == 1'b1, "R1 reset done", done_o, 1);
        chk(pc_o == 16'hE012, "R1 reset vector", pc_o, 16'hE012);
        chk(entered_o == 1'b0, "R1 not an entry", entered_o, 0);
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", {busy_o, done_o}, 0);

        // Directed corners
        entry(16'h1234, 8'h00, 8'hAA, 8'h55, 16'hBEEF, 16'hCAFE, 16'h01F0, 1'b0, 1'b1, 0); // irq taken
        entry(16'h4321, 8'h10, 8'h01, 8'h02, 16'h0304, 16'h0506, 16'h01E0, 1'b0, 1'b1, 0); // masked
        entry(16'h5A5A, 8'h10, 8'h11, 8'h22, 16'h3344, 16'h5566, 16'h01D0, 1'b1, 1'b0, 0); // nmi under mask
        entry(16'h0F0F, 8'h00, 8'h99, 8'h88, 16'h7766, 16'h5544, 16'h01C0, 1'b0, 1'b0, 0); // both: R4
        entry(16'h2222, 8'hEF, 8'h00, 8'hFF, 16'h0000, 16'hFFFF, 16'h01B0, 1'b1, 1'b1, 0); // none

        // R2: second step strobe during an entry is ignored
        entry(16'h6789, 8'h00, 8'h12, 8'h34, 16'h5678, 16'h9ABC, 16'h01A0, 1'b0, 1'b1, 4);
        extra = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk(extra == 0 && busy_o == 1'b0, "R2 busy step ignored", extra, 0);

        // Returns, including mask restore to 0 and simultaneous strobes
        do_ret(16'h0140, 1'b0, 8'h00);
        do_ret(16'h0150, 1'b0, 8'h01);
        do_ret(16'h0160, 1'b1, 8'h00);

        // Constrained random mix
        for (int it = 0; it < 60; it++) begin
            logic [15:0] sp;
            sp = 16'h0110 + 16'($urandom_range(0, 200));
            if ($urandom_range(0, 3) == 0) begin
                do_ret(sp, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 1)));
            end else begin
                entry(16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                      16'($urandom), 16'($urandom), sp,
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), 0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule